// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a memory-mapped timer whose counter steps down by one on each pulse of a tick enable. Software programs a start value, chooses one of two externally supplied tick enables and a wrap policy, then enables counting. When the counter is at zero and another tick arrives, it underflows. It then raises a level interrupt and either reloads from the programmed start value (periodic mode) or wraps to all ones (free-running mode).

The interrupt stays asserted until software writes any value to the clear address. The register bus is a plain synchronous port: a write is taken on the clock edge where the write strobe is high, and read data is a combinational function of the address. The block has no data stream, so it has no valid/ready handshake. Clock dividers that produce the tick enables live outside the block.

Top module: `dtimer_top`

## Requirements
- R1: After reset, the start-value register, the count, the control register and `irq` are all zero.
- R2: While the run bit (control bit 7) is set, each pulse of the selected tick lowers the count by one. While the run bit is clear, ticks leave the count unchanged, so writing the control register with bit 7 clear stops the counter.
- R3: Control bit 3 set selects `tick_fast` and bit 3 clear selects `tick_slow`. Pulses on the tick that is not selected have no effect.
- R4: A selected tick while the count is zero is an underflow. `irq` goes high on the next clock edge and stays high while later ticks arrive.
- R5: With control bit 6 set (periodic), an underflow loads the count from the start-value register.
- R6: With control bit 6 clear (free-running), an underflow sets the count to all ones.
- R7: A write of any data to offset 0x0C drops `irq` on the next edge. If an underflow occurs in the same cycle, `irq` stays high.
- R8: A write to offset 0x00 always updates the start-value register. It also sets the count to the written value only when the run bit is clear; while running, the count goes on undisturbed.
- R9: Reads return the start value at 0x00, the live count at 0x04, and the control register at 0x08 (bits 7, 6 and 3, all other bits zero). Every other address, including 0x0C and offsets not on a 4-byte boundary, reads zero. Writes to 0x04 are ignored.
- R10: A write takes effect on the rising edge where `bus_wr` is high. `bus_rdata` follows `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| tick_slow | input | 1 | Slow tick enable, one-cycle pulses |
| tick_fast | input | 1 | Fast tick enable, one-cycle pulses |
| irq | output | 1 | Level interrupt, set on underflow |

## Verification
The assertions check these rules on every cycle:
- each tick lowers the count by one;
- the count holds when there is no tick and no load;
- an underflow reloads the count in periodic mode and sets it to all ones in free-running mode;
- an underflow sets `irq`, a clear without an underflow drops it, and `irq` never rises without an underflow;
- a load while stopped copies the written value into the count.

Only the bench scenarios show the things that are visible at the bus:
- the register map, including reads of unused addresses that return zero and writes to the value register that are ignored;
- that the tick that is not selected has no effect;
- that a load while running leaves the live count alone;
- that an underflow beats a clear written in the same cycle, seen from the ports.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int RUN_BIT  = 7;
  localparam int PER_BIT  = 6;
  localparam int FAST_BIT = 3;

  localparam logic [1:0] IDX_LOAD = 2'd0;
  localparam logic [1:0] IDX_VAL  = 2'd1;
  localparam logic [1:0] IDX_CTRL = 2'd2;
  localparam logic [1:0] IDX_CLR  = 2'd3;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast;
  } tmr_ctrl_t;
endpackage

// File: rtl/dtimer_regs.sv
module dtimer_regs
  import dtimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output tmr_ctrl_t         ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic              load_wr,
  output logic              clr_wr
);
  logic       in_map;
  logic [1:0] idx;
  logic       unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign in_map = ((bus_addr >> 4) == '0) && (bus_addr[1:0] == 2'b00);
  assign idx    = bus_addr[3:2];

  assign load_wr = bus_wr && in_map && (idx == IDX_LOAD);
  assign clr_wr  = bus_wr && in_map && (idx == IDX_CLR);

  logic ctrl_wr;
  assign ctrl_wr = bus_wr && in_map && (idx == IDX_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.run      <= bus_wdata[RUN_BIT];
        ctrl_q.periodic <= bus_wdata[PER_BIT];
        ctrl_q.fast     <= bus_wdata[FAST_BIT];
      end
      if (load_wr) load_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      case (idx)
        IDX_LOAD: bus_rdata = DATA_W'(load_q);
        IDX_VAL:  bus_rdata = DATA_W'(cnt_val);
        IDX_CTRL: begin
          bus_rdata[RUN_BIT]  = ctrl_q.run;
          bus_rdata[PER_BIT]  = ctrl_q.periodic;
          bus_rdata[FAST_BIT] = ctrl_q.fast;
        end
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R8: a start-value write lands in the register on the next edge
  a_r8_load_reg: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> load_q == $past(bus_wdata[CNT_W-1:0]));
endmodule

// File: rtl/dtimer_count.sv
module dtimer_count
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctrl_t        ctrl_q,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt,
  output logic             underflow
);
  logic tick;
  logic preset;

  assign tick      = ctrl_q.run && (ctrl_q.fast ? tick_fast : tick_slow);
  assign underflow = tick && (cnt == '0);
  assign preset    = load_wr && !ctrl_q.run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (preset) begin
      cnt <= load_data;
    end else if (tick) begin
      if (cnt == '0) cnt <= ctrl_q.periodic ? load_q : '1;
      else           cnt <= cnt - 1'b1;
    end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !preset) |=> $stable(cnt));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl_q.periodic) |=> cnt == $past(load_q));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !ctrl_q.periodic) |=> (&cnt));
  a_r8_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> cnt == $past(load_data));
endmodule

// File: rtl/dtimer_irq.sv
module dtimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic clr_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (underflow) irq <= 1'b1;
    else if (clr_wr)    irq <= 1'b0;
  end

  a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !underflow) |=> !irq);
  a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(underflow));
endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
  import dtimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic              irq
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt;
  logic             load_wr;
  logic             clr_wr;
  logic             underflow;

  dtimer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt),
    .ctrl_q(ctrl_q), .load_q(load_q), .load_wr(load_wr), .clr_wr(clr_wr)
  );

  dtimer_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .load_wr(load_wr),
    .load_data(bus_wdata[CNT_W-1:0]), .load_q(load_q), .cnt(cnt),
    .underflow(underflow)
  );

  dtimer_irq irq_i (
    .clk(clk), .rst_n(rst_n), .underflow(underflow), .clr_wr(clr_wr),
    .irq(irq)
  );
endmodule

// File: tb/dtimer_top_tb_top.sv
module dtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dtimer_top #(.ADDR_W(8), .DATA_W(32), .CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    #1;
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic ticks(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 load", 8'h00, 32'h0);
    rd_chk("R1 value", 8'h04, 32'h0);
    rd_chk("R1 ctrl", 8'h08, 32'h0);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_load_stopped();
    wr(8'h00, 32'd5);
    rd_chk("R8 load while stopped sets value", 8'h04, 32'd5);
    rd_chk("R10 load readback", 8'h00, 32'd5);
    wr(8'h04, 32'd99);
    rd_chk("R9 value write ignored", 8'h04, 32'd5);
  endtask

  task automatic t_slow_count();
    wr(8'h08, 32'hFFFF_FFC0);
    rd_chk("R9 ctrl only bits 7,6", 8'h08, 32'hC0);
    ticks(1'b0, 2);
    rd_chk("R2 decrement", 8'h04, 32'd3);
    ticks(1'b1, 1);
    rd_chk("R3 fast tick ignored when slow selected", 8'h04, 32'd3);
    rd_chk("R9 clear offset reads zero", 8'h0C, 32'h0);
    rd_chk("R9 unused offset reads zero", 8'h10, 32'h0);
    rd_chk("R9 unaligned reads zero", 8'h06, 32'h0);
  endtask

  task automatic t_periodic_underflow();
    ticks(1'b0, 3);
    rd_chk("R2 reach zero", 8'h04, 32'd0);
    irq_chk("R4 no irq at zero", 1'b0);
    ticks(1'b0, 1);
    rd_chk("R5 reload on underflow", 8'h04, 32'd5);
    irq_chk("R4 irq on underflow", 1'b1);
    ticks(1'b0, 1);
    irq_chk("R4 irq level held", 1'b1);
    wr(8'h0C, 32'h0);
    irq_chk("R7 clear with zero data", 1'b0);
    rd_chk("R7 clear leaves count", 8'h04, 32'd4);
  endtask

  task automatic t_free_run();
    wr(8'h08, 32'h88);
    wr(8'h00, 32'd2);
    rd_chk("R8 load while running keeps count", 8'h04, 32'd4);
    rd_chk("R8 load register updated", 8'h00, 32'd2);
    ticks(1'b1, 4);
    rd_chk("R3 fast ticks counted", 8'h04, 32'd0);
    ticks(1'b1, 1);
    rd_chk("R6 wrap to all ones", 8'h04, 32'hFFFF_FFFF);
    irq_chk("R4 irq free-run underflow", 1'b1);
    ticks(1'b0, 1);
    rd_chk("R3 slow tick ignored when fast selected", 8'h04, 32'hFFFF_FFFF);
  endtask

  task automatic t_clear_race();
    wr(8'h0C, 32'hDEAD_BEEF);
    irq_chk("R7 clear with arbitrary data", 1'b0);
    wr(8'h08, 32'h0);
    ticks(1'b1, 1);
    ticks(1'b0, 1);
    rd_chk("R2 stopped holds", 8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'd1);
    rd_chk("R8 preset when stopped", 8'h04, 32'd1);
    wr(8'h08, 32'hC8);
    ticks(1'b1, 1);
    rd_chk("R2 to zero", 8'h04, 32'd0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1; tick_fast = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_fast = 1'b0;
    irq_chk("R7 underflow beats clear", 1'b1);
    rd_chk("R5 reload in race", 8'h04, 32'd1);
    wr(8'h0C, 32'h0);
    irq_chk("R7 later clear", 1'b0);
    wr(8'h08, 32'h48);
    ticks(1'b1, 2);
    rd_chk("R2 run bit clear stops", 8'h04, 32'd1);
    irq_chk("R2 no irq when stopped", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_stopped();
    t_slow_count();
    t_periodic_underflow();
    t_free_run();
    t_clear_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule